// File: doc/BRIEF.md
# Dual-channel disk interrupt status mirror

This block keeps the pending-interrupt state of two disk channels and presents it through a byte-addressed configuration register window. Each channel's pending flag appears at two addresses. One is a per-channel legacy status byte: channel 0 at byte 0x50 and channel 1 at byte 0x57. The other is a shared mode byte at 0x71, which also carries one masking bit per channel. Both copies are kept identical whichever address software uses to acknowledge an interrupt. A read-only enable byte at 0x51 reports which channels are switched on.

Each channel raises or drops a request level. When a channel's level changes, its pending flag takes the new level in both copies. Software clears a pending flag by writing a one to it at either address. The single level-sensitive interrupt output is high while any channel has a pending flag that its mask bit does not suppress.

The configuration port addresses 32-bit dwords and carries four byte enables. Writes take effect at the next clock edge. Reads are combinational from the current register state.

Top module: `ide_irq_mirror`

## Requirements
- R1: After reset, both pending flags are 0 and `irq_o` is low. Byte 0x51 reads 0x04, or 0x0C when `SECONDARY_EN` is 1. The mask bits hold `BLOCK_INIT`, with bit 0 for channel 0 and bit 1 for channel 1.
- R2: When `chan_irq_i[n]` changes level, the pending flag of channel n takes the new level after `IN_STAGES`+1 clock edges. The flag shows at byte 0x71 bit 2+n, and at byte 0x50 bit 2 (n=0) or byte 0x57 bit 4 (n=1). A level that is held steady does not set the flag again after it has been cleared.
- R3: A write with a one in byte 0x50 bit 2 clears channel 0's flag in both copies. A one in byte 0x57 bit 4 clears channel 1's flag in both copies. A zero in these bits changes nothing.
- R4: A write with a one in byte 0x71 bit 2 clears channel 0's flag in both copies. A one in bit 3 clears channel 1's flag in both copies.
- R5: All other bits are unaffected by writes. This covers the rest of bytes 0x50, 0x57 and 0x71, including the mask bits at 0x71 bits 4 (channel 0) and 5 (channel 1), and all of byte 0x51.
- R6: `irq_o` is high exactly when (flag0 AND NOT mask0) OR (flag1 AND NOT mask1).
- R7: When a level change on a channel and a write-one-to-clear of the same flag reach the registers in the same cycle, the level change wins. A clear of the other channel in that same write still takes effect.
- R8: The dword at address A reads byte 4A+k on lanes [8k+7:8k]. Unmapped bytes read 0. Lanes whose byte enable is 0 are not written. Enabled lanes are processed in ascending byte order within one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_irq_i | input | 2 | Request level from channel 0 (bit 0) and channel 1 (bit 1) |
| cfg_addr_i | input | CFG_ADDR_W | Dword address of the configuration access |
| cfg_be_i | input | 4 | Byte enables for the write |
| cfg_wr_i | input | 1 | Write strobe, one cycle per write |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Combinational read data for `cfg_addr_i` |
| irq_o | output | 1 | Combined level-sensitive interrupt |

## Verification
The hardest case to reach is a channel level change that lands in the same cycle as a software acknowledge of that flag. A plain sequence of accesses never lines these two up. The bench drives the channel input and the write strobe on the same falling edge, starting from a cleared flag, so the event and the clear meet at the same register update. Meanwhile the same write clears the other channel, to show that the acknowledge still applies there. A second instance with a nonzero mask and one input stage is swept in step with the default instance over every pair of old and new input levels, so the masking and the delayed event path are covered too.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;
   localparam int unsigned NUM_CH       = 2;
   localparam int unsigned OFF_LEG0     = 8'h50;
   localparam int unsigned OFF_CTRL     = 8'h51;
   localparam int unsigned OFF_LEG1     = 8'h57;
   localparam int unsigned OFF_MODE     = 8'h71;
   localparam int unsigned LEG0_BIT     = 2;
   localparam int unsigned LEG1_BIT     = 4;
   localparam int unsigned MODE_ST_LSB  = 2;
   localparam int unsigned MODE_BLK_LSB = 4;
   localparam int unsigned CTRL_EN0_BIT = 2;
   localparam int unsigned CTRL_EN1_BIT = 3;

   // two copies of the per-channel pending flags
   typedef struct packed {
      logic [NUM_CH-1:0] leg;
      logic [NUM_CH-1:0] mode;
   } irq_copies_t;
endpackage

// File: rtl/ide_irq_lvl_track.sv
module ide_irq_lvl_track #(
   parameter int unsigned STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic evt_o,
   output logic val_o
);
   logic cur;
   logic prev_q;

   generate
      if (STAGES == 0) begin : g_direct
         assign cur = lvl_i;
      end else begin : g_sync
         logic [STAGES-1:0] sync_q;
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '0;
            else if (STAGES == 1) sync_q <= lvl_i;
            else sync_q <= {sync_q[(STAGES>1 ? STAGES-2 : 0):0], lvl_i};
         end
         assign cur = sync_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= cur;
   end

   assign evt_o = cur != prev_q;
   assign val_o = cur;
endmodule

// File: rtl/ide_irq_cfg_apply.sv
module ide_irq_cfg_apply
   import ide_irq_pkg::*;
#(
   parameter int unsigned CFG_ADDR_W = 6
) (
   input  irq_copies_t           cur_i,
   input  logic                  wr_i,
   input  logic [CFG_ADDR_W-1:0] addr_i,
   input  logic [3:0]            be_i,
   input  logic [31:0]           wdata_i,
   output irq_copies_t           nxt_o
);
   localparam int unsigned BYTE_W = CFG_ADDR_W + 2;

   logic [BYTE_W-1:0] byte_addr;
   logic [7:0]        lane;

   // byte lanes in ascending address order; each clear is followed by a sync
   always_comb begin
      nxt_o     = cur_i;
      byte_addr = '0;
      lane      = '0;
      if (wr_i) begin
         for (int b = 0; b < 4; b++) begin
            if (be_i[b]) begin
               byte_addr = {addr_i, 2'(b)};
               lane      = wdata_i[8*b +: 8];
               if (byte_addr == BYTE_W'(OFF_LEG0)) begin
                  if (lane[LEG0_BIT]) nxt_o.leg[0] = 1'b0;
                  nxt_o.mode = nxt_o.leg;
               end else if (byte_addr == BYTE_W'(OFF_LEG1)) begin
                  if (lane[LEG1_BIT]) nxt_o.leg[1] = 1'b0;
                  nxt_o.mode = nxt_o.leg;
               end else if (byte_addr == BYTE_W'(OFF_MODE)) begin
                  for (int c = 0; c < NUM_CH; c++)
                     if (lane[MODE_ST_LSB+c]) nxt_o.mode[c] = 1'b0;
                  nxt_o.leg = nxt_o.mode;
               end
            end
         end
      end
   end
endmodule

// File: rtl/ide_irq_readmux.sv
module ide_irq_readmux
   import ide_irq_pkg::*;
#(
   parameter int unsigned CFG_ADDR_W   = 6,
   parameter bit          SECONDARY_EN = 1'b0
) (
   input  irq_copies_t           st_i,
   input  logic [NUM_CH-1:0]     blk_i,
   input  logic [CFG_ADDR_W-1:0] addr_i,
   output logic [31:0]           rdata_o
);
   localparam int unsigned BYTE_W = CFG_ADDR_W + 2;
   localparam logic [7:0] CTRL_VAL =
      8'((1 << CTRL_EN0_BIT) | (SECONDARY_EN ? (1 << CTRL_EN1_BIT) : 0));

   logic [BYTE_W-1:0] byte_addr;

   always_comb begin
      rdata_o   = '0;
      byte_addr = '0;
      for (int k = 0; k < 4; k++) begin
         byte_addr = {addr_i, 2'(k)};
         if (byte_addr == BYTE_W'(OFF_LEG0))
            rdata_o[8*k + LEG0_BIT] = st_i.leg[0];
         else if (byte_addr == BYTE_W'(OFF_LEG1))
            rdata_o[8*k + LEG1_BIT] = st_i.leg[1];
         else if (byte_addr == BYTE_W'(OFF_CTRL))
            rdata_o[8*k +: 8] = CTRL_VAL;
         else if (byte_addr == BYTE_W'(OFF_MODE)) begin
            rdata_o[8*k + MODE_ST_LSB  +: NUM_CH] = st_i.mode;
            rdata_o[8*k + MODE_BLK_LSB +: NUM_CH] = blk_i;
         end
      end
   end
endmodule

// File: rtl/ide_irq_combine.sv
module ide_irq_combine
   import ide_irq_pkg::*;
(
   input  logic [NUM_CH-1:0] flag_i,
   input  logic [NUM_CH-1:0] blk_i,
   output logic              irq_o
);
   assign irq_o = |(flag_i & ~blk_i);
endmodule

// File: rtl/ide_irq_mirror.sv
module ide_irq_mirror
   import ide_irq_pkg::*;
#(
   parameter int unsigned CFG_ADDR_W   = 6,
   parameter bit          SECONDARY_EN = 1'b0,
   parameter logic [1:0]  BLOCK_INIT   = 2'b00,
   parameter int unsigned IN_STAGES    = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            chan_irq_i,
   input  logic [CFG_ADDR_W-1:0] cfg_addr_i,
   input  logic [3:0]            cfg_be_i,
   input  logic                  cfg_wr_i,
   input  logic [31:0]           cfg_wdata_i,
   output logic [31:0]           cfg_rdata_o,
   output logic                  irq_o
);
   localparam logic [CFG_ADDR_W-1:0] MODE_DW   = CFG_ADDR_W'(OFF_MODE >> 2);
   localparam int unsigned           MODE_LANE = OFF_MODE & 3;
   localparam logic [CFG_ADDR_W-1:0] LEG0_DW   = CFG_ADDR_W'(OFF_LEG0 >> 2);
   localparam int unsigned           LEG0_LANE = OFF_LEG0 & 3;

   generate
      if (CFG_ADDR_W < 6 || CFG_ADDR_W > 30) begin : g_bad_addr_w
         $error("CFG_ADDR_W must reach byte 0x71 and stay below 31 bits");
      end
      if (IN_STAGES > 3) begin : g_bad_stages
         $error("IN_STAGES above 3 is not supported");
      end
   endgenerate

   logic [NUM_CH-1:0] evt;
   logic [NUM_CH-1:0] lvl;
   irq_copies_t       st_q, st_wr, st_d;
   logic [NUM_CH-1:0] blk_q;

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      ide_irq_lvl_track #(.STAGES(IN_STAGES)) u_track (
         .clk   (clk),
         .rst_n (rst_n),
         .lvl_i (chan_irq_i[n]),
         .evt_o (evt[n]),
         .val_o (lvl[n])
      );
   end

   ide_irq_cfg_apply #(.CFG_ADDR_W(CFG_ADDR_W)) u_apply (
      .cur_i   (st_q),
      .wr_i    (cfg_wr_i),
      .addr_i  (cfg_addr_i),
      .be_i    (cfg_be_i),
      .wdata_i (cfg_wdata_i),
      .nxt_o   (st_wr)
   );

   // channel events are applied after the write, so they take priority
   always_comb begin
      st_d = st_wr;
      for (int n = 0; n < NUM_CH; n++) begin
         if (evt[n]) begin
            st_d.leg[n]  = lvl[n];
            st_d.mode[n] = lvl[n];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= '0;
         blk_q <= BLOCK_INIT;
      end else begin
         st_q  <= st_d;
      end
   end

   ide_irq_readmux #(.CFG_ADDR_W(CFG_ADDR_W), .SECONDARY_EN(SECONDARY_EN)) u_rd (
      .st_i    (st_q),
      .blk_i   (blk_q),
      .addr_i  (cfg_addr_i),
      .rdata_o (cfg_rdata_o)
   );

   ide_irq_combine u_comb (
      .flag_i (st_q.mode),
      .blk_i  (blk_q),
      .irq_o  (irq_o)
   );

   // R2: both copies of each flag always agree
   p_copies_agree_r2: assert property (@(posedge clk) disable iff (!rst_n)
      st_q.leg == st_q.mode);

   // R7: an event sets the flag to the new level even under a same-cycle clear
   for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
      p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
         evt[n] |=> st_q.mode[n] == $past(lvl[n]));
   end

   // R5: no write and no event leaves the flags untouched
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_wr_i && evt == '0) |=> $stable(st_q));

   // R4: one at byte 0x71 bit 2 clears channel 0 absent an event
   p_mode_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_i && cfg_be_i[MODE_LANE] && cfg_addr_i == MODE_DW &&
       cfg_wdata_i[8*MODE_LANE + MODE_ST_LSB] && !evt[0]) |=> !st_q.leg[0]);

   // R3: one at byte 0x50 bit 2 clears channel 0 absent an event
   p_leg_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_i && cfg_be_i[LEG0_LANE] && cfg_addr_i == LEG0_DW &&
       cfg_wdata_i[8*LEG0_LANE + LEG0_BIT] && !evt[0]) |=> !st_q.mode[0]);

   // R6: a fully masked or empty flag set keeps the output low
   p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q.leg & ~blk_q) == '0) |-> !irq_o);
endmodule

// File: tb/ide_irq_mirror_bench.sv
module ide_irq_mirror_bench;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   localparam logic [1:0] BLK_A = 2'b00;
   localparam logic [1:0] BLK_B = 2'b01;

   logic        rst_n;
   logic [1:0]  lvl;
   logic [5:0]  addr;
   logic [3:0]  be;
   logic        wr;
   logic [31:0] wd;
   logic [31:0] rd_a, rd_b;
   logic        irq_a, irq_b;

   int n_run = 0;
   int n_fail = 0;
   logic [1:0] exp_st = 2'b00;
   logic [1:0] prev_lvl = 2'b00;

   ide_irq_mirror u_ide_irq_mirror (
      .clk(clk), .rst_n(rst_n), .chan_irq_i(lvl), .cfg_addr_i(addr),
      .cfg_be_i(be), .cfg_wr_i(wr), .cfg_wdata_i(wd),
      .cfg_rdata_o(rd_a), .irq_o(irq_a));

   ide_irq_mirror #(.SECONDARY_EN(1'b1), .BLOCK_INIT(BLK_B), .IN_STAGES(1))
   u_ide_irq_mirror_alt (
      .clk(clk), .rst_n(rst_n), .chan_irq_i(lvl), .cfg_addr_i(addr),
      .cfg_be_i(be), .cfg_wr_i(wr), .cfg_wdata_i(wd),
      .cfg_rdata_o(rd_b), .irq_o(irq_b));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic model_write(input logic [5:0] a, input logic [3:0] b, input logic [31:0] d);
      if (a == 6'h14 && b[0] && d[2])  exp_st[0] = 1'b0;
      if (a == 6'h15 && b[3] && d[28]) exp_st[1] = 1'b0;
      if (a == 6'h1C && b[1]) begin
         if (d[10]) exp_st[0] = 1'b0;
         if (d[11]) exp_st[1] = 1'b0;
      end
   endtask

   task automatic set_lvl(input logic [1:0] l);
      @(negedge clk);
      lvl = l;
      for (int n = 0; n < 2; n++)
         if (l[n] != prev_lvl[n]) exp_st[n] = l[n];
      prev_lvl = l;
      repeat (3) @(negedge clk);
   endtask

   task automatic cfg_write(input logic [5:0] a, input logic [3:0] b, input logic [31:0] d);
      @(negedge clk);
      addr = a; be = b; wd = d; wr = 1'b1;
      model_write(a, b, d);
      @(negedge clk);
      wr = 1'b0; be = 4'h0;
      repeat (2) @(negedge clk);
   endtask

   task automatic check_all(input string req);
      @(negedge clk);
      addr = 6'h14; #1;
      chk({req, " dword 0x50 main"}, rd_a, {16'h0, 8'h04, 5'b0, exp_st[0], 2'b0});
      chk({req, " dword 0x50 alt"},  rd_b, {16'h0, 8'h0C, 5'b0, exp_st[0], 2'b0});
      addr = 6'h15; #1;
      chk({req, " dword 0x54 main"}, rd_a, {3'b0, exp_st[1], 4'b0, 24'h0});
      chk({req, " dword 0x54 alt"},  rd_b, {3'b0, exp_st[1], 4'b0, 24'h0});
      addr = 6'h1C; #1;
      chk({req, " dword 0x70 main"}, rd_a, {16'h0, 2'b0, BLK_A, exp_st, 2'b0, 8'h0});
      chk({req, " dword 0x70 alt"},  rd_b, {16'h0, 2'b0, BLK_B, exp_st, 2'b0, 8'h0});
      chk({req, " irq main"}, {31'b0, irq_a}, {31'b0, |(exp_st & ~BLK_A)});
      chk({req, " irq alt"},  {31'b0, irq_b}, {31'b0, |(exp_st & ~BLK_B)});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual still running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; lvl = 2'b00; addr = '0; be = '0; wr = 1'b0; wd = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state, including enable byte and masks
      check_all("R1");

      // R8: unmapped dword reads zero
      @(negedge clk); addr = 6'h00; #1;
      chk("R8 unmapped dword", rd_a, 32'h0);

      // R2 R6: every old/new level pair, then a clear through each path
      for (int p = 0; p < 4; p++) begin
         for (int q = 0; q < 4; q++) begin
            set_lvl(2'(p));
            set_lvl(2'(q));
            check_all("R2 R6 sweep");
            case ((p*4 + q) % 3)
               0: cfg_write(6'h14, 4'hF, 32'hFFFF_FFFF);
               1: cfg_write(6'h15, 4'hF, 32'hFFFF_FFFF);
               default: cfg_write(6'h1C, 4'hF, 32'hFFFF_FFFF);
            endcase
            check_all("R3 R4 R5 clear");
            set_lvl(2'(q));
            check_all("R2 held level");
         end
      end

      // R3: zeros leave the flags set
      set_lvl(2'b00);
      set_lvl(2'b11);
      cfg_write(6'h14, 4'hF, 32'h0);
      cfg_write(6'h15, 4'hF, 32'h0);
      cfg_write(6'h1C, 4'hF, 32'h0);
      check_all("R3 zero write");

      // R8: disabled lane is not written
      cfg_write(6'h1C, 4'b1101, 32'hFFFF_FFFF);
      check_all("R8 lane disabled");

      // R8 R3: partial enables on 0x50 clear only channel 0
      cfg_write(6'h14, 4'b0011, 32'h0000_FFFF);
      check_all("R8 partial lanes");

      // R4: mode byte clears channel 1
      cfg_write(6'h1C, 4'b0010, 32'h0000_0800);
      check_all("R4 mode clear ch1");

      // R7: rising event meets a same-cycle clear; other channel clears
      set_lvl(2'b00);
      set_lvl(2'b10);
      @(negedge clk);
      lvl = 2'b11; prev_lvl = 2'b11;
      addr = 6'h1C; be = 4'b0010; wd = 32'h0000_0C00; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0; be = 4'h0;
      exp_st = 2'b01;
      repeat (3) @(negedge clk);
      check_all("R7 event beats clear");

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule